// File: doc/BRIEF.md
# Dot-Matrix Row-Scan and Segment Generator

This block refreshes a multiplexed dot-matrix liquid-crystal panel from a byte-wide dot memory. The memory holds 32 display lines grouped into four pages of eight lines, each line 80 columns wide. A column byte holds one bit per line of its page. A scan index steps through the active rows, one step per row tick. While one row is on the panel, a fetch engine reads the next row column by column into a staging register. At the next row tick that register moves into the segment latch as a whole, so a row is never shown half-updated. A one-hot common vector selects the panel row that is being driven.

Several settings act on the picture. A start line scrolls the picture vertically. The duty setting picks a 16-row or a 32-row scan. A column-order switch mirrors the panel horizontally. A display enable blanks the panel, and a static mode lights every segment; static mode with the display disabled is a power-save state. Two copies can share one 32-row panel. The master drives the frame alternation signal and owns scan rows 0 to 15. The slave owns rows 16 to 31 and realigns its scan whenever the alternation signal changes.

Top module: `dotmatrix_scan`

## Requirements
- R1: A memory read drives `mem_addr` = {page, column}: bits [8:7] are line[4:3] and bits [6:0] are the column. `mem_rdata` arrives one clock after the read, and the segment bit is `mem_rdata[line[2:0]]`. A read never addresses a column of 80 or above.
- R2: Scan index s shows memory line (cfg_start_line + s) mod 32.
- R3: With cfg_duty32 = 0 the scan index wraps from 15 to 0. With cfg_duty32 = 1 it wraps from 31 to 0. A scan index at or above the last active row also wraps to 0.
- R4: A master (cfg_master = 1) raises com_o[s] for scan index s below 16. A slave raises com_o[s-16] for s of 16 or more. Otherwise com_o is zero, and com_o never has more than one bit set.
- R5: With cfg_normal = 1, segment k shows column k. With cfg_normal = 0, segment k shows column 79 - k.
- R6: A row tick is sampled at a clock edge. seg_o and com_o show the new row one edge later. Before the first tick, seg_o and com_o are zero.
- R7: With cfg_disp_on = 0, seg_o and com_o are all zero from the next clock edge, whatever the memory holds.
- R8: With cfg_disp_on = 1 and cfg_static = 1, every bit of seg_o is 1 from the next clock edge, and com_o keeps scanning.
- R9: With cfg_static = 1 and cfg_disp_on = 0 (power save), mem_rd_en stays low. A fetch that is paused this way continues once power save ends.
- R10: On a master, fr_out toggles at the tick edge that moves the scan index to 0 and holds its value at every other edge. On a slave, fr_out is 0.
- R11: On a slave, a change of fr_in resets the scan index to 0 at the next edge and starts a new fetch of row 1. The following tick shows scan index 1.
- R12: A synchronous reset clears seg_o, com_o and fr_out and starts the fetch of scan row 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| row_tick | input | 1 | One-cycle pulse that starts the next row period |
| cfg_master | input | 1 | 1: master, 0: slave |
| cfg_duty32 | input | 1 | 1: 32-row scan, 0: 16-row scan |
| cfg_start_line | input | 5 | Memory line shown at scan index 0 |
| cfg_normal | input | 1 | 1: normal column order, 0: mirrored |
| cfg_disp_on | input | 1 | Display enable |
| cfg_static | input | 1 | Light all segments |
| mem_rd_en | output | 1 | Dot-memory read strobe |
| mem_addr | output | 9 | Dot-memory address {page, column} |
| mem_rdata | input | 8 | Dot-memory read data, one-cycle latency |
| fr_in | input | 1 | Frame alternation input (used by a slave) |
| fr_out | output | 1 | Frame alternation output (driven by a master) |
| seg_o | output | 61 | Segment drive |
| com_o | output | 16 | Common select, one-hot or zero |

## Verification
The assertions assume a memory that returns read data one cycle after the strobe. They also assume that the column order and start line stay fixed while a row fetch runs, and that row ticks are far enough apart for a full 61-column fetch. The bench keeps within these limits: it spaces ticks 73 clocks apart, and it changes settings only after a fetch has finished, just before the next tick. The slave's fr_in is toggled only in cycles without a tick. The random part of the stimulus varies the memory contents, start line, column order and duty from row to row. The directed part covers the wrap at both duties, static mode, blanking, power save and slave realignment.

// File: rtl/dotmatrix_scan_pkg.sv
package dotmatrix_scan_pkg;
  localparam int LINE_W = 5;                 // 32 memory lines
  localparam int PAGE_W = 2;                 // 4 pages
  localparam int BIT_W  = LINE_W - PAGE_W;   // line within a page
  localparam int BYTE_W = 2 ** BIT_W;

  typedef logic [LINE_W-1:0] line_t;

  // step the scan index, wrapping after the last active row of the duty
  function automatic line_t scan_advance(line_t s, logic duty32);
    line_t last;
    last = duty32 ? line_t'(2 ** LINE_W - 1) : line_t'(2 ** (LINE_W - 1) - 1);
    return (s >= last) ? '0 : s + line_t'(1);
  endfunction
endpackage

// File: rtl/dms_sequencer.sv
module dms_sequencer
  import dotmatrix_scan_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  row_tick,
  input  logic  cfg_master,
  input  logic  cfg_duty32,
  input  logic  fr_in,
  output line_t next_scan,
  output line_t cur_scan,
  output logic  shown_valid,
  output logic  fr_out,
  output logic  fetch_start
);
  logic fr_in_d;
  logic fr_q;
  logic resync;

  // slave realigns on any change of the alternation input
  assign resync      = !cfg_master && (fr_in != fr_in_d);
  assign fetch_start = row_tick || resync;
  assign fr_out      = fr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      next_scan   <= '0;
      cur_scan    <= '0;
      shown_valid <= 1'b0;
      fr_in_d     <= 1'b0;
      fr_q        <= 1'b0;
    end else begin
      fr_in_d <= fr_in;
      if (resync) begin
        cur_scan  <= '0;
        next_scan <= scan_advance('0, cfg_duty32);
      end else if (row_tick) begin
        cur_scan    <= next_scan;
        next_scan   <= scan_advance(next_scan, cfg_duty32);
        shown_valid <= 1'b1;
      end
      if (!cfg_master) begin
        fr_q <= 1'b0;
      end else if (row_tick && next_scan == '0) begin
        fr_q <= ~fr_q;
      end
    end
  end
endmodule

// File: rtl/dms_fetch.sv
module dms_fetch
  import dotmatrix_scan_pkg::*;
#(
  parameter int NUM_SEG = 61,
  parameter int NUM_COL = 80,
  localparam int COL_W  = $clog2(NUM_COL),
  localparam int ADDR_W = PAGE_W + COL_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               hold,
  input  line_t              next_scan,
  input  line_t              cfg_start_line,
  input  logic               cfg_normal,
  input  logic [BYTE_W-1:0]  mem_rdata,
  output logic               mem_rd_en,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [NUM_SEG-1:0] stage
);
  logic [COL_W-1:0] k_q;
  logic [COL_W-1:0] pipe_k;
  logic [COL_W-1:0] col;
  logic [BIT_W-1:0] pipe_bit;
  logic             busy;
  logic             pipe_v;
  line_t            line;

  assign line      = cfg_start_line + next_scan;
  assign col       = cfg_normal ? k_q : COL_W'(NUM_COL - 1) - k_q;
  assign mem_rd_en = busy && !hold;
  assign mem_addr  = {line[LINE_W-1:BIT_W], col};

  always_ff @(posedge clk) begin
    if (rst) begin
      k_q      <= '0;
      busy     <= 1'b1;
      pipe_v   <= 1'b0;
      pipe_k   <= '0;
      pipe_bit <= '0;
      stage    <= '0;
    end else begin
      pipe_v   <= mem_rd_en;
      pipe_k   <= k_q;
      pipe_bit <= line[BIT_W-1:0];
      if (start) begin
        k_q  <= '0;
        busy <= 1'b1;
      end else if (mem_rd_en) begin
        k_q <= k_q + COL_W'(1);
        if (k_q == COL_W'(NUM_SEG - 1)) busy <= 1'b0;
      end
      if (pipe_v) stage[pipe_k] <= mem_rdata[pipe_bit];
    end
  end
endmodule

// File: rtl/dms_drive.sv
module dms_drive
  import dotmatrix_scan_pkg::*;
#(
  parameter int NUM_SEG = 61,
  parameter int NUM_COM = 16,
  localparam int COM_W  = $clog2(NUM_COM)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               row_tick,
  input  logic [NUM_SEG-1:0] stage,
  input  line_t              cur_scan,
  input  logic               shown_valid,
  input  logic               cfg_master,
  input  logic               cfg_disp_on,
  input  logic               cfg_static,
  output logic [NUM_SEG-1:0] seg_o,
  output logic [NUM_COM-1:0] com_o
);
  logic [NUM_SEG-1:0] latch_q;
  logic [NUM_COM-1:0] com_sel;
  logic               own_half;

  // master serves the lower half of the scan, slave the upper half
  assign own_half = cfg_master ? !cur_scan[LINE_W-1] : cur_scan[LINE_W-1];

  for (genvar i = 0; i < NUM_COM; i++) begin : g_com
    assign com_sel[i] = (cur_scan[COM_W-1:0] == COM_W'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
      seg_o   <= '0;
      com_o   <= '0;
    end else begin
      if (row_tick) latch_q <= stage;
      if (!cfg_disp_on) begin
        seg_o <= '0;
        com_o <= '0;
      end else begin
        com_o <= (shown_valid && own_half) ? com_sel : '0;
        seg_o <= cfg_static ? '1 : (shown_valid ? latch_q : '0);
      end
    end
  end
endmodule

// File: rtl/dotmatrix_scan.sv
module dotmatrix_scan
  import dotmatrix_scan_pkg::*;
#(
  parameter int NUM_SEG = 61,
  parameter int NUM_COL = 80,
  parameter int NUM_COM = 16,
  localparam int COL_W  = $clog2(NUM_COL),
  localparam int ADDR_W = PAGE_W + COL_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               row_tick,
  input  logic               cfg_master,
  input  logic               cfg_duty32,
  input  logic [LINE_W-1:0]  cfg_start_line,
  input  logic               cfg_normal,
  input  logic               cfg_disp_on,
  input  logic               cfg_static,
  output logic               mem_rd_en,
  output logic [ADDR_W-1:0]  mem_addr,
  input  logic [BYTE_W-1:0]  mem_rdata,
  input  logic               fr_in,
  output logic               fr_out,
  output logic [NUM_SEG-1:0] seg_o,
  output logic [NUM_COM-1:0] com_o
);
  line_t              next_scan;
  line_t              cur_scan;
  logic               shown_valid;
  logic               fetch_start;
  logic               power_save;
  logic [NUM_SEG-1:0] stage;

  assign power_save = cfg_static && !cfg_disp_on;

  dms_sequencer u_seq (
    .clk         (clk),
    .rst         (rst),
    .row_tick    (row_tick),
    .cfg_master  (cfg_master),
    .cfg_duty32  (cfg_duty32),
    .fr_in       (fr_in),
    .next_scan   (next_scan),
    .cur_scan    (cur_scan),
    .shown_valid (shown_valid),
    .fr_out      (fr_out),
    .fetch_start (fetch_start)
  );

  dms_fetch #(.NUM_SEG(NUM_SEG), .NUM_COL(NUM_COL)) u_fetch (
    .clk            (clk),
    .rst            (rst),
    .start          (fetch_start),
    .hold           (power_save),
    .next_scan      (next_scan),
    .cfg_start_line (cfg_start_line),
    .cfg_normal     (cfg_normal),
    .mem_rdata      (mem_rdata),
    .mem_rd_en      (mem_rd_en),
    .mem_addr       (mem_addr),
    .stage          (stage)
  );

  dms_drive #(.NUM_SEG(NUM_SEG), .NUM_COM(NUM_COM)) u_drive (
    .clk         (clk),
    .rst         (rst),
    .row_tick    (row_tick),
    .stage       (stage),
    .cur_scan    (cur_scan),
    .shown_valid (shown_valid),
    .cfg_master  (cfg_master),
    .cfg_disp_on (cfg_disp_on),
    .cfg_static  (cfg_static),
    .seg_o       (seg_o),
    .com_o       (com_o)
  );
endmodule

// File: rtl/dotmatrix_scan_chk.sv
module dotmatrix_scan_chk #(
  parameter int NUM_SEG = 61,
  parameter int NUM_COL = 80,
  parameter int NUM_COM = 16,
  parameter int COL_W   = 7,
  parameter int ADDR_W  = 9
) (
  input logic               clk,
  input logic               rst,
  input logic               row_tick,
  input logic               cfg_master,
  input logic               cfg_disp_on,
  input logic               cfg_static,
  input logic               mem_rd_en,
  input logic [ADDR_W-1:0]  mem_addr,
  input logic               fr_out,
  input logic [NUM_SEG-1:0] seg_o,
  input logic [NUM_COM-1:0] com_o
);
  a_r1_col_in_range: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> (int'(mem_addr[COL_W-1:0]) < NUM_COL));

  a_r4_com_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(com_o));

  a_r7_blank_when_off: assert property (@(posedge clk) disable iff (rst)
    !cfg_disp_on |=> (com_o == '0 && seg_o == '0));

  a_r8_static_all_lit: assert property (@(posedge clk) disable iff (rst)
    (cfg_disp_on && cfg_static) |=> (seg_o == '1));

  a_r9_no_read_power_save: assert property (@(posedge clk) disable iff (rst)
    (cfg_static && !cfg_disp_on) |-> !mem_rd_en);

  a_r10_fr_steady: assert property (@(posedge clk) disable iff (rst)
    (!row_tick && $stable(cfg_master)) |=> $stable(fr_out));
endmodule

bind dotmatrix_scan dotmatrix_scan_chk #(
  .NUM_SEG(NUM_SEG), .NUM_COL(NUM_COL), .NUM_COM(NUM_COM),
  .COL_W(COL_W), .ADDR_W(ADDR_W)
) i_chk (
  .clk         (clk),
  .rst         (rst),
  .row_tick    (row_tick),
  .cfg_master  (cfg_master),
  .cfg_disp_on (cfg_disp_on),
  .cfg_static  (cfg_static),
  .mem_rd_en   (mem_rd_en),
  .mem_addr    (mem_addr),
  .fr_out      (fr_out),
  .seg_o       (seg_o),
  .com_o       (com_o)
);

// File: tb/test_dotmatrix_scan.sv
`timescale 1ns/1ps
module test_dotmatrix_scan;
  localparam int GAP = 70;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        row_tick = 1'b0;
  logic        cfg_master = 1'b1;
  logic        cfg_duty32 = 1'b0;
  logic [4:0]  cfg_start_line = 5'd5;
  logic        cfg_normal = 1'b1;
  logic        cfg_disp_on = 1'b1;
  logic        cfg_static = 1'b0;
  logic        fr_in = 1'b0;
  logic        mem_rd_en;
  logic [8:0]  mem_addr;
  logic [7:0]  mem_rdata;
  logic        fr_out;
  logic [60:0] seg_o;
  logic [15:0] com_o;

  logic [7:0]  mem [4][128];

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  // model state
  int          m_next, m_cur;
  bit          m_valid, m_fr;
  logic [60:0] m_stage, m_latch;

  always #4 clk = ~clk;

  dotmatrix_scan i_dotmatrix_scan (
    .clk(clk), .rst(rst), .row_tick(row_tick), .cfg_master(cfg_master),
    .cfg_duty32(cfg_duty32), .cfg_start_line(cfg_start_line),
    .cfg_normal(cfg_normal), .cfg_disp_on(cfg_disp_on), .cfg_static(cfg_static),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .fr_in(fr_in), .fr_out(fr_out), .seg_o(seg_o), .com_o(com_o)
  );

  // dot memory with one-cycle read latency (R1)
  always_ff @(posedge clk)
    if (mem_rd_en) mem_rdata <= mem[mem_addr[8:7]][mem_addr[6:0]];

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  function automatic logic [60:0] row_bits(int scan);
    logic [60:0] r;
    int line;
    line = (int'(cfg_start_line) + scan) % 32;
    for (int k = 0; k < 61; k++) begin
      int col;
      col = cfg_normal ? k : 79 - k;
      r[k] = mem[line / 8][col][line % 8];
    end
    return r;
  endfunction

  function automatic int wrap(int s);
    int last;
    last = cfg_duty32 ? 31 : 15;
    return (s >= last) ? 0 : s + 1;
  endfunction

  function automatic logic [15:0] com_exp();
    if (!cfg_disp_on || !m_valid) return 16'h0;
    if (cfg_master && m_cur < 16) return 16'h1 << m_cur;
    if (!cfg_master && m_cur >= 16) return 16'h1 << (m_cur - 16);
    return 16'h0;
  endfunction

  function automatic logic [60:0] seg_exp();
    if (!cfg_disp_on) return '0;
    if (cfg_static) return '1;
    return m_valid ? m_latch : '0;
  endfunction

  task automatic check_out(string tag);
    chk({tag, " seg"}, 64'(seg_o), 64'(seg_exp()));
    chk({tag, " com R4"}, 64'(com_o), 64'(com_exp()));
    chk("R10 fr_out", 64'(fr_out), 64'(m_fr));
  endtask

  task automatic apply_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_next = 0; m_cur = 0; m_valid = 0; m_fr = 0;
    m_latch = '0;
    m_stage = row_bits(0);
  endtask

  // tick sampled at edge E, outputs checked after edge E+1 (R6)
  task automatic tick(string tag);
    @(negedge clk) row_tick = 1'b1;
    @(negedge clk) row_tick = 1'b0;
    m_latch = m_stage;
    m_cur   = m_next;
    m_valid = 1;
    if (cfg_master && m_next == 0) m_fr = !m_fr;
    m_next  = wrap(m_next);
    m_stage = row_bits(m_next);
    @(negedge clk);
    check_out(tag);
    repeat (GAP) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd1307));
    for (int p = 0; p < 4; p++)
      for (int c = 0; c < 128; c++)
        mem[p][c] = 8'($urandom);

    // reset state and first reads (R12, R1)
    @(negedge clk);
    apply_reset();
    #1;
    chk("R1 addr col0", 64'(mem_addr), 64'({2'(5 / 8), 7'd0}));
    chk("R1 rd_en", 64'(mem_rd_en), 64'd1);
    chk("R12 seg", 64'(seg_o), 64'd0);
    chk("R12 com", 64'(com_o), 64'd0);
    chk("R12 fr", 64'(fr_out), 64'd0);
    @(negedge clk);
    chk("R1 addr col1", 64'(mem_addr), 64'({2'd0, 7'd1}));
    repeat (GAP) @(negedge clk);
    chk("R6 before first tick com", 64'(com_o), 64'd0);

    // 1/16 duty, normal order: wraps past 15 (R2, R3)
    for (int i = 0; i < 20; i++) tick("R2 R3 duty16");

    // mirrored columns (R5)
    cfg_normal = 1'b0;
    for (int i = 0; i < 6; i++) tick("R5 mirror");

    // 1/32 duty with random start line and order (R2, R3, R5)
    cfg_duty32 = 1'b1;
    for (int i = 0; i < 40; i++) begin
      cfg_start_line = 5'($urandom);
      cfg_normal     = 1'($urandom);
      tick("R2 R3 R5 duty32");
    end

    // static drive (R8)
    cfg_static = 1'b1;
    @(negedge clk); @(negedge clk);
    check_out("R8 static");
    tick("R8 static tick");
    cfg_static = 1'b0;

    // display off (R7)
    cfg_disp_on = 1'b0;
    @(negedge clk); @(negedge clk);
    check_out("R7 off");
    tick("R7 off tick");

    // power save: no reads (R9)
    cfg_static = 1'b1;
    tick("R9 power save");
    begin
      int reads = 0;
      for (int i = 0; i < GAP; i++) begin
        @(negedge clk);
        if (mem_rd_en) reads++;
      end
      chk("R9 reads during power save", 64'(reads), 64'd0);
    end
    cfg_static  = 1'b0;
    cfg_disp_on = 1'b1;
    repeat (GAP) @(negedge clk);
    tick("R9 resume");
    tick("R9 resume next");

    // random mix including duty changes (R3)
    for (int i = 0; i < 30; i++) begin
      cfg_start_line = 5'($urandom);
      cfg_normal     = 1'($urandom);
      cfg_duty32     = 1'($urandom);
      tick("R3 random");
    end

    // slave, 1/32 duty, mirrored (R4, R10, R1)
    cfg_master = 1'b0;
    cfg_duty32 = 1'b1;
    cfg_normal = 1'b0;
    cfg_start_line = 5'd9;
    @(negedge clk);
    apply_reset();
    #1;
    chk("R1 slave addr col79", 64'(mem_addr), 64'({2'd1, 7'd79}));
    repeat (GAP) @(negedge clk);
    for (int i = 0; i < 34; i++) tick("R4 slave");

    // slave realign on fr_in change (R11)
    fr_in = ~fr_in;
    @(negedge clk);
    m_cur = 0; m_next = 1; m_stage = row_bits(1);
    @(negedge clk);
    chk("R11 resync com", 64'(com_o), 64'd0);
    repeat (GAP) @(negedge clk);
    for (int i = 0; i < 17; i++) tick("R11 after resync");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule